// File: doc/BRIEF.md
# Virtual Function BAR Address Decoder

This block works out the bus address window that one virtual function occupies behind a single VF BAR. All virtual functions of a physical function share one set of BAR registers in the SR-IOV capability of the physical function. Each virtual function's window is that shared base plus its own index times the aperture size. The block takes a routing ID and finds the virtual function index in three steps: it subtracts the first-VF routing ID (the PF routing ID plus the VF offset), checks that the difference is a whole multiple of the VF stride, and checks that the quotient is below the number of enabled virtual functions.

The block also reads the BAR type field, which selects a one-dword or a two-dword base. It clears the address bits below the aperture and produces the first and last address of the window. It raises a mapped flag only when memory decode is enabled, the routing ID names a live virtual function, the configuration is legal and the window does not run past the top of its address space. It also supplies the write mask that the configuration-write path applies to the shared BAR dwords. All outputs are registered, with one cycle of latency.

Top module: `vf_bar_decoder`

## Requirements
- R1: For a routing ID equal to PF routing ID + VF offset + k × stride, with stride ≠ 0 and k below the enabled count, `vf_valid` is 1 and `vf_num` is k, one cycle after the inputs are presented.
- R2: A routing ID below PF routing ID + VF offset, off the stride grid, with index ≥ enabled count, or with stride 0 gives `vf_valid` = 0, `vf_num` = 0, a zero window and `mapped` = 0.
- R3: `vf_base` is the shared base with all bits below 2^`size_log2` cleared, plus `vf_num` × 2^`size_log2`, truncated to 64 bits.
- R4: `bar_type` 2'b10 selects a 64-bit base {`bar_hi`,`bar_lo`}. `bar_type` 2'b00 selects a 32-bit base from `bar_lo` alone, and `bar_hi` then has no effect on any output.
- R5: `vf_last` = `vf_base` + 2^`size_log2` − 1.
- R6: `mapped` is 0 when the window's last address exceeds 2^32−1 for a 32-bit BAR, or 2^64−1 for a 64-bit BAR.
- R7: `mapped` is 0 whenever `mem_en` was 0. With `mem_en` = 1, a valid VF, a legal configuration and no overflow, `mapped` is 1.
- R8: The write mask is ~(2^`size_log2` − 1). `wmask_lo` holds bits 31:0. `wmask_hi` holds bits 63:32 for a 64-bit BAR and is 0 for a 32-bit BAR.
- R9: `cfg_err` is 1 under any of these conditions: `bar_type` is 2'b01 or 2'b11; `bar_slot` ≥ 6 (slot 6 is the expansion ROM); a 64-bit BAR sits in slot 5; `size_log2` < 4; `size_log2` > 31 on a 32-bit BAR. When `cfg_err` is 1, the window and both masks are 0 and `mapped` is 0.
- R10: A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vf_rid | input | RID_W | Routing ID being decoded |
| pf_rid | input | RID_W | Routing ID of the physical function |
| vf_offset | input | RID_W | Distance from the PF routing ID to the first VF |
| vf_stride | input | RID_W | Routing ID spacing between VFs |
| num_vfs | input | RID_W | Number of enabled VFs |
| bar_lo | input | 32 | Shared BAR low dword |
| bar_hi | input | 32 | Shared BAR high dword (64-bit BARs only) |
| bar_type | input | 2 | Locator type: 00 = 32-bit, 10 = 64-bit |
| bar_slot | input | 3 | BAR slot index (0..5 legal) |
| size_log2 | input | 6 | log2 of the per-VF aperture in bytes |
| mem_en | input | 1 | Memory decode enable |
| vf_num | output | RID_W | Decoded VF index |
| vf_valid | output | 1 | Routing ID names a live VF |
| vf_base | output | 64 | First address of the VF window |
| vf_last | output | 64 | Last address of the VF window |
| mapped | output | 1 | Window is decoded on the bus |
| cfg_err | output | 1 | Illegal BAR configuration |
| wmask_lo | output | 32 | Write mask for the low BAR dword |
| wmask_hi | output | 32 | Write mask for the high BAR dword |

## Verification
The bench targets these corner cases:
- A routing ID one step off the stride grid. A decoder that truncates the division would accept it as the neighbouring VF.
- The index equal to the enabled count. An off-by-one range check would map a VF that does not exist.
- A 32-bit window ending exactly at 2^32−1 and one ending just past it. A design without the wrap check would claim an address range the BAR cannot describe.
- A 32-bit BAR with garbage in the high dword, the ROM slot, a 64-bit BAR in the last slot, and a too-small aperture. A wrong decoder would leak `bar_hi` into the base, or map an illegal BAR with a non-zero mask.

// File: rtl/vfbar_pkg.sv
// Shared constants for the VF BAR address decoder.
// Assumes memory BARs only; the locator type codes follow the standard
// BAR type field (bits 2:1 of the low dword).
package vfbar_pkg;
    localparam int          ADDR_W     = 64;
    localparam int          DWORD_W    = 32;
    localparam int          MIN_LOG2   = 4;
    localparam logic [1:0]  TYPE_MEM32 = 2'b00;
    localparam logic [1:0]  TYPE_MEM64 = 2'b10;
    localparam logic [2:0]  SLOT_ROM   = 3'd6;
    localparam logic [2:0]  SLOT_LAST  = 3'd5;
endpackage

// File: rtl/vfb_index_calc.sv
// Finds the VF index from a routing ID.
// Assumes: the first VF sits at pf_rid + vf_offset and later VFs follow
// every vf_stride IDs. A restoring divider, unrolled with generate,
// gives the quotient and the remainder. Purely combinational.
module vfb_index_calc #(
    parameter int RID_W = 16
) (
    input  logic [RID_W-1:0] vf_rid,
    input  logic [RID_W-1:0] pf_rid,
    input  logic [RID_W-1:0] vf_offset,
    input  logic [RID_W-1:0] vf_stride,
    input  logic [RID_W-1:0] num_vfs,
    output logic [RID_W-1:0] idx,
    output logic             idx_ok
);
    logic [RID_W:0]   first_rid;
    logic             below_first;
    logic [RID_W-1:0] delta;
    logic [RID_W-1:0] quo;
    logic [RID_W-1:0] rem_s [0:RID_W];

    // Routing ID of VF 0 and distance from it
    assign first_rid   = {1'b0, pf_rid} + {1'b0, vf_offset};
    assign below_first = {1'b0, vf_rid} < first_rid;
    assign delta       = vf_rid - first_rid[RID_W-1:0];

    assign rem_s[0] = '0;
    for (genvar i = 0; i < RID_W; i++) begin : g_div
        localparam int BIT = RID_W - 1 - i;
        wire [RID_W:0] shifted = {rem_s[i], delta[BIT]};
        wire           fits    = shifted >= {1'b0, vf_stride};
        assign quo[BIT]   = fits;
        assign rem_s[i+1] = fits ? RID_W'(shifted - {1'b0, vf_stride})
                                 : shifted[RID_W-1:0];
    end

    // Index is valid only on the stride grid and below the enabled count
    always_comb begin
        idx_ok = !below_first && (vf_stride != '0) &&
                 (rem_s[RID_W] == '0) && (quo < num_vfs);
        idx    = idx_ok ? quo : '0;
    end
endmodule

// File: rtl/vfb_cfg_check.sv
// Checks that the shared BAR configuration is legal and decodes the width.
// Assumes memory BARs only: the ROM slot, reserved type codes and
// apertures below the minimum count as errors.
module vfb_cfg_check
    import vfbar_pkg::*;
(
    input  logic [1:0] bar_type,
    input  logic [2:0] bar_slot,
    input  logic [5:0] size_log2,
    output logic       is64,
    output logic       cfg_err
);
    // Flag every illegal combination of type, slot and aperture
    always_comb begin
        is64    = (bar_type == TYPE_MEM64);
        cfg_err = 1'b0;
        if (bar_type != TYPE_MEM32 && bar_type != TYPE_MEM64) cfg_err = 1'b1;
        if (bar_slot >= SLOT_ROM)                              cfg_err = 1'b1;
        if (is64 && bar_slot == SLOT_LAST)                     cfg_err = 1'b1;
        if (size_log2 < 6'(MIN_LOG2))                          cfg_err = 1'b1;
        if (!is64 && size_log2 > 6'd31)                        cfg_err = 1'b1;
    end
endmodule

// File: rtl/vfb_window_calc.sv
// Computes one VF's window from the shared base.
// Assumes size_log2 <= 63. The arithmetic is kept wider than 64 bits so
// that running past the top of the address space can be seen.
module vfb_window_calc
    import vfbar_pkg::*;
#(
    parameter int RID_W = 16
) (
    input  logic [DWORD_W-1:0] bar_lo,
    input  logic [DWORD_W-1:0] bar_hi,
    input  logic               is64,
    input  logic [5:0]         size_log2,
    input  logic [RID_W-1:0]   idx,
    output logic [ADDR_W-1:0]  base,
    output logic [ADDR_W-1:0]  last,
    output logic               wrap
);
    localparam int EW = ADDR_W + RID_W + 1;

    logic [EW-1:0]     size_e;
    logic [EW-1:0]     step;
    logic [EW-1:0]     last_w;
    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] aligned;

    // Shared base, aligned, then offset by index times aperture
    always_comb begin
        size_e  = EW'(1) << size_log2;
        raw     = is64 ? {bar_hi, bar_lo} : {{DWORD_W{1'b0}}, bar_lo};
        aligned = raw & ~(size_e[ADDR_W-1:0] - 64'd1);
        step    = EW'(idx) << size_log2;
        base    = aligned + step[ADDR_W-1:0];
        last_w  = EW'(aligned) + step + size_e - EW'(1);
        last    = last_w[ADDR_W-1:0];
        wrap    = is64 ? (|last_w[EW-1:ADDR_W]) : (|last_w[EW-1:DWORD_W]);
    end
endmodule

// File: rtl/vfb_wmask.sv
// Produces the write mask for the shared BAR dwords: only address bits
// at or above the aperture are writable. Assumes cfg_err zeroes the mask.
module vfb_wmask
    import vfbar_pkg::*;
(
    input  logic               is64,
    input  logic               cfg_err,
    input  logic [5:0]         size_log2,
    output logic [DWORD_W-1:0] mask_lo,
    output logic [DWORD_W-1:0] mask_hi
);
    logic [ADDR_W-1:0] full;

    // Inverse of aperture minus one, split over the two dwords
    always_comb begin
        full    = ~((64'd1 << size_log2) - 64'd1);
        mask_lo = cfg_err ? '0 : full[DWORD_W-1:0];
        mask_hi = (cfg_err || !is64) ? '0 : full[ADDR_W-1:DWORD_W];
    end
endmodule

// File: rtl/vf_bar_decoder.sv
// Top of the VF BAR address decoder. It registers the index, the window,
// the mapped flag and the masks once per cycle.
// Assumes: inputs are stable for the cycle they are sampled in; reset is
// synchronous and active low.
module vf_bar_decoder
    import vfbar_pkg::*;
#(
    parameter int RID_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RID_W-1:0]   vf_rid,
    input  logic [RID_W-1:0]   pf_rid,
    input  logic [RID_W-1:0]   vf_offset,
    input  logic [RID_W-1:0]   vf_stride,
    input  logic [RID_W-1:0]   num_vfs,
    input  logic [31:0]        bar_lo,
    input  logic [31:0]        bar_hi,
    input  logic [1:0]         bar_type,
    input  logic [2:0]         bar_slot,
    input  logic [5:0]         size_log2,
    input  logic               mem_en,
    output logic [RID_W-1:0]   vf_num,
    output logic               vf_valid,
    output logic [63:0]        vf_base,
    output logic [63:0]        vf_last,
    output logic               mapped,
    output logic               cfg_err,
    output logic [31:0]        wmask_lo,
    output logic [31:0]        wmask_hi
);
    logic [RID_W-1:0]  idx;
    logic              idx_ok;
    logic              is64;
    logic              bad_cfg;
    logic [ADDR_W-1:0] base_c;
    logic [ADDR_W-1:0] last_c;
    logic              wrap;
    logic [31:0]       mlo;
    logic [31:0]       mhi;
    logic              live;

    vfb_index_calc #(.RID_W(RID_W)) u_index (
        .vf_rid(vf_rid), .pf_rid(pf_rid), .vf_offset(vf_offset),
        .vf_stride(vf_stride), .num_vfs(num_vfs),
        .idx(idx), .idx_ok(idx_ok)
    );

    vfb_cfg_check u_cfg (
        .bar_type(bar_type), .bar_slot(bar_slot), .size_log2(size_log2),
        .is64(is64), .cfg_err(bad_cfg)
    );

    vfb_window_calc #(.RID_W(RID_W)) u_window (
        .bar_lo(bar_lo), .bar_hi(bar_hi), .is64(is64),
        .size_log2(size_log2), .idx(idx),
        .base(base_c), .last(last_c), .wrap(wrap)
    );

    vfb_wmask u_wmask (
        .is64(is64), .cfg_err(bad_cfg), .size_log2(size_log2),
        .mask_lo(mlo), .mask_hi(mhi)
    );

    assign live = idx_ok && !bad_cfg;

    // Output register stage with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vf_num   <= '0;
            vf_valid <= 1'b0;
            vf_base  <= '0;
            vf_last  <= '0;
            mapped   <= 1'b0;
            cfg_err  <= 1'b0;
            wmask_lo <= '0;
            wmask_hi <= '0;
        end else begin
            vf_num   <= idx;
            vf_valid <= idx_ok;
            vf_base  <= live ? base_c : '0;
            vf_last  <= live ? last_c : '0;
            mapped   <= live && mem_en && !wrap;
            cfg_err  <= bad_cfg;
            wmask_lo <= mlo;
            wmask_hi <= mhi;
        end
    end

    // R1/R2: a valid index is always below the enabled count
    a_r2_index_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        vf_valid |-> (vf_num < $past(num_vfs)));

    // R7: no mapping without memory decode enabled
    a_r7_needs_mem_en: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> $past(mem_en));

    // R5: a mapped window spans a power-of-two number of bytes
    a_r5_span_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> ($countones(vf_last - vf_base + 64'd1) == 1));

    // R3: a mapped base is aligned to its own span
    a_r3_base_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mapped |-> ((vf_base & (vf_last - vf_base)) == 64'd0));

    // R6: a mapped 32-bit window stays below 2^32
    a_r6_no_wrap32: assert property (@(posedge clk) disable iff (!rst_n)
        (mapped && wmask_hi == 32'd0) |-> (vf_last[63:32] == 32'd0));

    // R9: an illegal configuration maps nothing and writes nothing
    a_r9_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!mapped && wmask_lo == 32'd0 && wmask_hi == 32'd0 &&
                     vf_base == 64'd0));
endmodule

// File: tb/vf_bar_decoder_bench.sv
// Self-checking bench: directed corners, then seeded random stimulus,
// compared with a model written from the requirements.
module vf_bar_decoder_bench;
    localparam int RID_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [RID_W-1:0]  vf_rid = '0, pf_rid = '0, vf_offset = '0;
    logic [RID_W-1:0]  vf_stride = '0, num_vfs = '0;
    logic [31:0]       bar_lo = '0, bar_hi = '0;
    logic [1:0]        bar_type = '0;
    logic [2:0]        bar_slot = '0;
    logic [5:0]        size_log2 = 6'd12;
    logic              mem_en = 1'b0;
    logic [RID_W-1:0]  vf_num;
    logic              vf_valid, mapped, cfg_err;
    logic [63:0]       vf_base, vf_last;
    logic [31:0]       wmask_lo, wmask_hi;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    int unsigned seed_sink;
    int unsigned cycles   = 0;

    logic [RID_W-1:0] e_num;
    logic             e_valid, e_mapped, e_err;
    logic [63:0]      e_base, e_last;
    logic [31:0]      e_mlo, e_mhi;

    vf_bar_decoder #(.RID_W(RID_W)) u_vf_bar_decoder (
        .clk(clk), .rst_n(rst_n), .vf_rid(vf_rid), .pf_rid(pf_rid),
        .vf_offset(vf_offset), .vf_stride(vf_stride), .num_vfs(num_vfs),
        .bar_lo(bar_lo), .bar_hi(bar_hi), .bar_type(bar_type),
        .bar_slot(bar_slot), .size_log2(size_log2), .mem_en(mem_en),
        .vf_num(vf_num), .vf_valid(vf_valid), .vf_base(vf_base),
        .vf_last(vf_last), .mapped(mapped), .cfg_err(cfg_err),
        .wmask_lo(wmask_lo), .wmask_hi(wmask_hi)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model of the requirements
    task automatic model();
        logic [16:0]  first;
        logic         below, is64;
        int unsigned  delta, q, r;
        logic [127:0] size, raw, aligned, base, last;
        logic         wrap, ok;
        first = {1'b0, pf_rid} + {1'b0, vf_offset};
        below = {1'b0, vf_rid} < first;
        delta = 32'(RID_W'(vf_rid - first[15:0]));
        q = 0; r = 1;
        if (vf_stride != 0) begin q = delta / vf_stride; r = delta % vf_stride; end
        ok = !below && vf_stride != 0 && r == 0 && q < num_vfs;
        is64 = (bar_type == 2'b10);
        e_err = (bar_type == 2'b01) || (bar_type == 2'b11) || (bar_slot >= 3'd6) ||
                (is64 && bar_slot == 3'd5) || (size_log2 < 6'd4) ||
                (!is64 && size_log2 > 6'd31);
        size    = 128'd1 << size_log2;
        raw     = is64 ? {64'd0, bar_hi, bar_lo} : {96'd0, bar_lo};
        aligned = raw & ~(size - 128'd1);
        base    = aligned + 128'(q) * size;
        last    = base + size - 128'd1;
        wrap    = is64 ? (last >= (128'd1 << 64)) : (last >= (128'd1 << 32));
        e_valid  = ok;
        e_num    = ok ? RID_W'(q) : '0;
        e_base   = (ok && !e_err) ? base[63:0] : 64'd0;
        e_last   = (ok && !e_err) ? last[63:0] : 64'd0;
        e_mapped = ok && !e_err && mem_en && !wrap;
        e_mlo    = e_err ? 32'd0 : ~(size[31:0] - 32'd1);
        e_mhi    = (e_err || !is64) ? 32'd0 : ~(size[63:32] - ((size[31:0] == 0) ? 32'd1 : 32'd0));
    endtask

    // Inputs were set at a falling edge; sample one full cycle later
    task automatic step_check(input string ctx);
        model();
        @(negedge clk);
        chk({"R1 ", ctx}, "vf_valid", 64'(vf_valid), 64'(e_valid));
        chk({"R1 ", ctx}, "vf_num",   64'(vf_num),   64'(e_num));
        chk({"R3 ", ctx}, "vf_base",  vf_base,       e_base);
        chk({"R5 ", ctx}, "vf_last",  vf_last,       e_last);
        chk({"R7 ", ctx}, "mapped",   64'(mapped),   64'(e_mapped));
        chk({"R8 ", ctx}, "wmask_lo", 64'(wmask_lo), 64'(e_mlo));
        chk({"R8 ", ctx}, "wmask_hi", 64'(wmask_hi), 64'(e_mhi));
        chk({"R9 ", ctx}, "cfg_err",  64'(cfg_err),  64'(e_err));
    endtask

    task automatic setup(input logic [15:0] pf, input logic [15:0] off,
                         input logic [15:0] str, input logic [15:0] n,
                         input logic [1:0] typ, input logic [2:0] slot,
                         input logic [5:0] lg, input logic en);
        pf_rid = pf; vf_offset = off; vf_stride = str; num_vfs = n;
        bar_type = typ; bar_slot = slot; size_log2 = lg; mem_en = en;
    endtask

    initial begin
        seed_sink = $urandom(32'h5EED_0042);
        setup(16'h0100, 16'd4, 16'd2, 16'd8, 2'b00, 3'd0, 6'd12, 1'b1);
        bar_lo = 32'h8000_0ABC; vf_rid = 16'h0104;
        repeat (3) @(negedge clk);
        // R10: reset clears outputs even with live inputs
        chk("R10 reset", "mapped",   64'(mapped),  64'd0);
        chk("R10 reset", "vf_base",  vf_base,      64'd0);
        chk("R10 reset", "wmask_lo", 64'(wmask_lo), 64'd0);
        chk("R10 reset", "vf_valid", 64'(vf_valid), 64'd0);
        rst_n = 1'b1;

        // R1: first VF, then VF 3; low bits of the base cleared (R3)
        step_check("vf0");
        chk("R3 vf0", "base literal", vf_base, 64'h0000_0000_8000_0000);
        vf_rid = 16'h010A; step_check("vf3");
        chk("R3 vf3", "base literal", vf_base, 64'h0000_0000_8000_3000);
        chk("R5 vf3", "last literal", vf_last, 64'h0000_0000_8000_3FFF);

        // R2: below first, off grid, index == count, stride zero
        vf_rid = 16'h0103; step_check("R2 below");
        chk("R2 below", "vf_valid", 64'(vf_valid), 64'd0);
        vf_rid = 16'h0105; step_check("R2 offgrid");
        chk("R2 offgrid", "vf_valid", 64'(vf_valid), 64'd0);
        vf_rid = 16'h0114; step_check("R2 count");
        chk("R2 count", "mapped", 64'(mapped), 64'd0);
        vf_rid = 16'h0112; step_check("R2 lastvf");
        chk("R2 lastvf", "vf_num", 64'(vf_num), 64'd7);
        vf_stride = 16'd0; vf_rid = 16'h0104; step_check("R2 stride0");
        chk("R2 stride0", "vf_valid", 64'(vf_valid), 64'd0);

        // R4: 64-bit uses bar_hi, 32-bit ignores it
        setup(16'h0000, 16'd1, 16'd1, 16'd4, 2'b10, 3'd2, 6'd16, 1'b1);
        bar_hi = 32'h0000_0012; bar_lo = 32'h0004_000C; vf_rid = 16'd3;
        step_check("R4 b64");
        chk("R4 b64", "base literal", vf_base, 64'h0000_0012_0006_0000);
        bar_type = 2'b00; bar_hi = 32'hDEAD_BEEF; step_check("R4 b32");
        chk("R4 b32", "base upper", {32'd0, vf_base[63:32]}, 64'd0);
        chk("R4 b32", "wmask_hi", 64'(wmask_hi), 64'd0);

        // R6: 32-bit window ending exactly at 2^32-1, then one past it
        setup(16'h0000, 16'd1, 16'd1, 16'd4, 2'b00, 3'd0, 6'd28, 1'b1);
        bar_lo = 32'hE000_0000; vf_rid = 16'd2; step_check("R6 edge");
        chk("R6 edge", "mapped", 64'(mapped), 64'd1);
        vf_rid = 16'd3; step_check("R6 wrap32");
        chk("R6 wrap32", "mapped", 64'(mapped), 64'd0);
        bar_type = 2'b10; bar_hi = 32'hFFFF_FFFF; step_check("R6 wrap64");
        chk("R6 wrap64", "mapped", 64'(mapped), 64'd0);

        // R7: memory decode off
        setup(16'h0000, 16'd1, 16'd1, 16'd4, 2'b00, 3'd0, 6'd12, 1'b0);
        bar_lo = 32'h1000_0000; vf_rid = 16'd1; step_check("R7 off");
        chk("R7 off", "mapped", 64'(mapped), 64'd0);

        // R8: 64-bit mask with aperture above 4 GiB
        setup(16'h0000, 16'd1, 16'd1, 16'd4, 2'b10, 3'd0, 6'd33, 1'b1);
        step_check("R8 big");
        chk("R8 big", "wmask_hi", 64'(wmask_hi), 64'h0000_0000_FFFF_FFFE);

        // R9: ROM slot, 64-bit in slot 5, tiny aperture, reserved type, huge 32-bit
        setup(16'h0000, 16'd1, 16'd1, 16'd4, 2'b00, 3'd6, 6'd12, 1'b1);
        step_check("R9 rom");
        chk("R9 rom", "cfg_err", 64'(cfg_err), 64'd1);
        bar_slot = 3'd5; bar_type = 2'b10; step_check("R9 slot5");
        chk("R9 slot5", "cfg_err", 64'(cfg_err), 64'd1);
        bar_slot = 3'd0; bar_type = 2'b00; size_log2 = 6'd3; step_check("R9 tiny");
        bar_type = 2'b01; size_log2 = 6'd12; step_check("R9 rsvd");
        bar_type = 2'b00; size_log2 = 6'd32; step_check("R9 huge32");

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int unsigned k;
            pf_rid    = 16'($urandom);
            vf_offset = 16'($urandom_range(1, 64));
            vf_stride = 16'($urandom_range(1, 4));
            num_vfs   = 16'($urandom_range(0, 8));
            k         = $urandom_range(0, 9);
            vf_rid    = pf_rid + vf_offset + 16'(k) * vf_stride +
                        (($urandom_range(0, 3) == 0) ? 16'd1 : 16'd0);
            bar_type  = ($urandom_range(0, 9) == 0) ? 2'b01 :
                        (($urandom_range(0, 1) == 0) ? 2'b00 : 2'b10);
            bar_slot  = 3'($urandom_range(0, 6));
            size_log2 = 6'($urandom_range(3, 34));
            bar_lo    = $urandom;
            bar_hi    = $urandom;
            mem_en    = ($urandom_range(0, 9) != 0);
            step_check("random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule